// File: doc/BRIEF.md
# Supercapacitor Charger Supervisor

This block is the digital supervisor of a linear supercapacitor charger. It receives comparator decisions that have already been digitized and an active-low enable pin. The decisions are: input above its undervoltage level, input above its overvoltage level, enough input-to-output headroom to leave sleep, output overcurrent, thermal regulation, thermal shutdown, the current-set resistor found shorted or open, and the output at its charged level. From them it chooses an operating mode. It drives a charge-enable and a current-reference selection to the analog loop, plus two active-low indicator outputs: charge status and input power good.

Recoverable conditions stop charging only while they last. These are input overvoltage and thermal shutdown. Latched conditions hold the charger off until the enable pin is released and pulled low again, or until input power is lost and comes back. These are a current-set short found at startup and an overcurrent that persists past a deglitch time. Two counters set the timing, both derived from the clock frequency: the overcurrent deglitch and the status blink used for faults. Every flag input passes through a two-flop synchronizer before use.

Top module: `sc_chg_supervisor`

## Requirements
- R1: After reset, or whenever the undervoltage flag `in_ok` is low, `mode` is 0 (off). `chg_en` is 0, `iref_sel` is 0, and both `stat_n` and `pg_n` are 1 (released).
- R2: With `in_ok` high, `ce_n` low, no latched fault and `headroom_ok` low, `mode` is 2 (sleep) and `chg_en` is 0.
- R3: `pg_n` is 0 exactly when `in_ok` is high, `headroom_ok` is high and `in_ov` is low. Otherwise it is 1.
- R4: `ce_n` high with `in_ok` high gives `mode` 1 (disabled) and `chg_en` 0, from any state. A floating enable is treated by the pad as low (enabled).
- R5: Charging is entered only through `mode` 3 (current-set check). If `iset_short` is high during the check, `mode` becomes 6 (fault) with `chg_en` 0. If it is low, `mode` becomes 4 (active) with `chg_en` 1.
- R6: While active, `iref_sel` is 2 (zero current) if `iset_open` is high. Otherwise it is 3 (reduced, thermal regulation) if `treg` is high, and 1 (full) if not. `treg` does not change `mode`.
- R7: Input overvoltage while active moves `mode` to 5 (standby) with `chg_en` 0. Charging returns to active by itself once `in_ov` clears.
- R8: Thermal shutdown moves `mode` to 5 with `chg_en` 0, and charging resumes once `tshut` clears. The status output does not blink in this case.
- R9: `ocp` held high for DGL_US microseconds of clocks while active latches `mode` 6. A pulse shorter than that leaves `mode` at 4.
- R10: A latched fault stays at `mode` 6 after its cause goes away. It clears only when `ce_n` goes high then low, or when `in_ok` goes low then high.
- R11: Outside mode 0, `stat_n` is 1 when `out_full` is low and 0 when it is high. In mode 6, or in mode 5 with `in_ov` high, `stat_n` instead toggles with a half period of CLK_HZ/(2*BLINK_HZ) clocks.
- R12: With `out_full` held high while active there is no termination: `mode` stays 4 and `chg_en` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Active-low charge enable pin |
| in_ok | input | 1 | Input above undervoltage threshold |
| in_ov | input | 1 | Input above overvoltage threshold |
| headroom_ok | input | 1 | Input exceeds output plus sleep-exit headroom |
| ocp | input | 1 | Output current above overcurrent limit |
| treg | input | 1 | Junction at thermal regulation limit |
| tshut | input | 1 | Thermal shutdown comparator (with hysteresis) |
| iset_short | input | 1 | Current-set resistor detected shorted |
| iset_open | input | 1 | Current-set resistor detected open |
| out_full | input | 1 | Feedback above 98 % of reference |
| mode | output | 3 | Operating mode code |
| chg_en | output | 1 | Charger pass element enable |
| iref_sel | output | 2 | Current reference selection |
| stat_n | output | 1 | Active-low charge status indicator |
| pg_n | output | 1 | Active-low power-good indicator |

## Verification
The bench builds the block with CLK_HZ = 1 MHz, DGL_US = 100 and BLINK_HZ = 10 kHz. That gives a 100-cycle overcurrent deglitch and a 50-cycle blink half period. A pulse just short of the deglitch and one just past it can both be run in a few hundred cycles, and several full blink periods can be watched. The real 1 Hz rate would need a count that a short run never reaches, yet it uses the same derived limits.

// File: rtl/sc_chg_pkg.sv
package sc_chg_pkg;

  typedef enum logic [2:0] {
    M_OFF    = 3'd0,
    M_DIS    = 3'd1,
    M_SLEEP  = 3'd2,
    M_CHECK  = 3'd3,
    M_ACTIVE = 3'd4,
    M_STBY   = 3'd5,
    M_FAULT  = 3'd6
  } mode_e;

  typedef enum logic [1:0] {
    I_OFF   = 2'd0,
    I_FULL  = 2'd1,
    I_ZERO  = 2'd2,
    I_THERM = 2'd3
  } iref_e;

  // positions in the synchronized flag vector
  localparam int F_UV    = 0;
  localparam int F_OV    = 1;
  localparam int F_HD    = 2;
  localparam int F_OCP   = 3;
  localparam int F_TREG  = 4;
  localparam int F_TSHUT = 5;
  localparam int F_SHORT = 6;
  localparam int F_OPEN  = 7;
  localparam int F_FULL  = 8;
  localparam int F_CEN   = 9;
  localparam int NFLAG   = 10;

endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sc_deglitch.sv
module sc_deglitch #(
  parameter int CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic flag,
  output logic trip
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm || !flag) begin
      cnt  <= '0;
      trip <= 1'b0;
    end else if (cnt == CW'(CYC - 1)) begin
      trip <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      trip <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_blink.sv
module sc_blink #(
  parameter int HALF = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic phase
);
  localparam int CW = $clog2(HALF + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (cnt == CW'(HALF - 1)) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sc_chg_supervisor.sv
module sc_chg_supervisor
  import sc_chg_pkg::*;
#(
  parameter int CLK_HZ   = 100_000_000,
  parameter int DGL_US   = 100,
  parameter int BLINK_HZ = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ce_n,
  input  logic       in_ok,
  input  logic       in_ov,
  input  logic       headroom_ok,
  input  logic       ocp,
  input  logic       treg,
  input  logic       tshut,
  input  logic       iset_short,
  input  logic       iset_open,
  input  logic       out_full,
  output logic [2:0] mode,
  output logic       chg_en,
  output logic [1:0] iref_sel,
  output logic       stat_n,
  output logic       pg_n
);
  localparam int DGL_CYC    = (CLK_HZ / 1_000_000) * DGL_US;
  localparam int BLINK_HALF = CLK_HZ / (2 * BLINK_HZ);

  logic [NFLAG-1:0] flg_raw, flg_s;
  logic uv_s, ov_s, hd_s, ocp_s, treg_s, ts_s, short_s, open_s, full_s, ce_s;

  assign flg_raw[F_UV]    = in_ok;
  assign flg_raw[F_OV]    = in_ov;
  assign flg_raw[F_HD]    = headroom_ok;
  assign flg_raw[F_OCP]   = ocp;
  assign flg_raw[F_TREG]  = treg;
  assign flg_raw[F_TSHUT] = tshut;
  assign flg_raw[F_SHORT] = iset_short;
  assign flg_raw[F_OPEN]  = iset_open;
  assign flg_raw[F_FULL]  = out_full;
  assign flg_raw[F_CEN]   = ce_n;

  sc_sync #(.WIDTH(NFLAG)) u_sync (
    .clk(clk), .rst(rst), .d(flg_raw), .q(flg_s)
  );

  assign uv_s    = flg_s[F_UV];
  assign ov_s    = flg_s[F_OV];
  assign hd_s    = flg_s[F_HD];
  assign ocp_s   = flg_s[F_OCP];
  assign treg_s  = flg_s[F_TREG];
  assign ts_s    = flg_s[F_TSHUT];
  assign short_s = flg_s[F_SHORT];
  assign open_s  = flg_s[F_OPEN];
  assign full_s  = flg_s[F_FULL];
  assign ce_s    = flg_s[F_CEN];

  mode_e state, nxt;
  logic  flt_latch, flt_set, flt_next;
  logic  ocp_trip, blink_en, blink_ph;

  sc_deglitch #(.CYC(DGL_CYC)) u_dgl (
    .clk(clk), .rst(rst), .arm(state == M_ACTIVE), .flag(ocp_s), .trip(ocp_trip)
  );

  assign blink_en = (state == M_FAULT) || (state == M_STBY && ov_s);

  sc_blink #(.HALF(BLINK_HALF)) u_blink (
    .clk(clk), .rst(rst), .en(blink_en), .phase(blink_ph)
  );

  // latched fault: set by startup short check or deglitched overcurrent,
  // cleared by enable release or input loss
  always_comb begin
    flt_set  = (state == M_CHECK && short_s) || ocp_trip;
    flt_next = (!uv_s || ce_s) ? 1'b0 : (flt_latch || flt_set);
  end

  always_comb begin
    if (!uv_s)                   nxt = M_OFF;
    else if (ce_s)               nxt = M_DIS;
    else if (flt_next)           nxt = M_FAULT;
    else if (!hd_s)              nxt = M_SLEEP;
    else if (ov_s || ts_s)       nxt = M_STBY;
    else if (state == M_ACTIVE || state == M_CHECK) nxt = M_ACTIVE;
    else                         nxt = M_CHECK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= M_OFF;
      flt_latch <= 1'b0;
      chg_en    <= 1'b0;
      iref_sel  <= I_OFF;
      stat_n    <= 1'b1;
      pg_n      <= 1'b1;
    end else begin
      state     <= nxt;
      flt_latch <= flt_next;
      chg_en    <= (nxt == M_ACTIVE);
      if (nxt != M_ACTIVE)  iref_sel <= I_OFF;
      else if (open_s)      iref_sel <= I_ZERO;
      else if (treg_s)      iref_sel <= I_THERM;
      else                  iref_sel <= I_FULL;
      pg_n <= !(uv_s && hd_s && !ov_s);
      if (nxt == M_OFF)     stat_n <= 1'b1;
      else if (blink_en)    stat_n <= blink_ph;
      else                  stat_n <= !full_s;
    end
  end

  assign mode = state;

endmodule

// File: rtl/sc_chg_checker.sv
module sc_chg_checker
  import sc_chg_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [2:0] mode,
  input logic       chg_en,
  input logic       pg_n,
  input logic       uv_s,
  input logic       ov_s,
  input logic       ce_s
);
  assert_off_on_uvlo_R1: assert property (@(posedge clk) disable iff (rst)
    !uv_s |=> mode == M_OFF);

  assert_pg_not_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !pg_n |-> (mode != M_OFF && mode != M_SLEEP));

  assert_disable_R4: assert property (@(posedge clk) disable iff (rst)
    (ce_s && uv_s) |=> mode == M_DIS);

  assert_entry_via_check_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(chg_en) |-> $past(mode) == M_CHECK);

  assert_ov_leaves_active_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == M_ACTIVE && ov_s) |=> mode != M_ACTIVE);

  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (mode == M_FAULT && uv_s && !ce_s) |=> mode == M_FAULT);
endmodule

bind sc_chg_supervisor sc_chg_checker u_chk (
  .clk(clk), .rst(rst), .mode(mode), .chg_en(chg_en), .pg_n(pg_n),
  .uv_s(uv_s), .ov_s(ov_s), .ce_s(ce_s)
);

// File: tb/sc_chg_supervisor_bench.sv
module sc_chg_supervisor_bench;
  localparam int CLK_HZ   = 1_000_000;
  localparam int DGL_US   = 100;
  localparam int BLINK_HZ = 10_000;
  localparam int DGL      = (CLK_HZ / 1_000_000) * DGL_US;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b0, in_ok = 1'b0, in_ov = 1'b0, headroom_ok = 1'b0, ocp = 1'b0;
  logic treg = 1'b0, tshut = 1'b0, iset_short = 1'b0, iset_open = 1'b0, out_full = 1'b0;
  logic [2:0] mode;
  logic chg_en, stat_n, pg_n;
  logic [1:0] iref_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sc_chg_supervisor #(.CLK_HZ(CLK_HZ), .DGL_US(DGL_US), .BLINK_HZ(BLINK_HZ)) u_sc_chg_supervisor (
    .clk(clk), .rst(rst), .ce_n(ce_n), .in_ok(in_ok), .in_ov(in_ov),
    .headroom_ok(headroom_ok), .ocp(ocp), .treg(treg), .tshut(tshut),
    .iset_short(iset_short), .iset_open(iset_open), .out_full(out_full),
    .mode(mode), .chg_en(chg_en), .iref_sel(iref_sel), .stat_n(stat_n), .pg_n(pg_n)
  );

  function automatic int exp_mode(bit uv, bit ce, bit hd, bit ov, bit ts);
    if (!uv) return 0;
    if (ce) return 1;
    if (!hd) return 2;
    if (ov || ts) return 5;
    return 4;
  endfunction

  function automatic int exp_pg(bit uv, bit hd, bit ov);
    return (uv && hd && !ov) ? 0 : 1;
  endfunction

  function automatic int exp_iref(int m, bit opn, bit tr);
    if (m != 4) return 0;
    if (opn) return 2;
    if (tr) return 3;
    return 1;
  endfunction

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_toggles(int n, output int t);
    logic prev;
    t = 0;
    prev = stat_n;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (stat_n != prev) t++;
      prev = stat_n;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t;
    void'($urandom(32'h5eed_c0de));
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(4);
    // R1 reset state
    chk(mode, 0, "R1 mode after reset");
    chk(chg_en, 0, "R1 chg_en after reset");
    chk(iref_sel, 0, "R1 iref after reset");
    chk(stat_n, 1, "R1 stat_n after reset");
    chk(pg_n, 1, "R1 pg_n after reset");

    // R2 directed sleep
    in_ok = 1; headroom_ok = 0;
    wait_cyc(10);
    chk(mode, 2, "R2 sleep mode");
    chk(chg_en, 0, "R2 sleep chg_en");

    // random flag patterns (no latched causes)
    for (int i = 0; i < 60; i++) begin
      int em;
      in_ok       = ($urandom % 4) != 0;
      ce_n        = ($urandom % 6) == 0;
      headroom_ok = ($urandom % 4) != 0;
      in_ov       = ($urandom % 5) == 0;
      tshut       = ($urandom % 6) == 0;
      treg        = $urandom % 2;
      iset_open   = ($urandom % 5) == 0;
      out_full    = $urandom % 2;
      wait_cyc(10);
      em = exp_mode(in_ok, ce_n, headroom_ok, in_ov, tshut);
      chk(mode, em, "R1/R2/R4/R7/R8 random mode");
      chk(chg_en, em == 4, "R5 random chg_en");
      chk(pg_n, exp_pg(in_ok, headroom_ok, in_ov), "R3 random pg_n");
      chk(iref_sel, exp_iref(em, iset_open, treg), "R6 random iref");
      if (em == 0) chk(stat_n, 1, "R1 random stat_n");
      else if (!(em == 5 && in_ov)) chk(stat_n, !out_full, "R11 random stat_n");
    end

    // clean active baseline
    in_ok = 1; ce_n = 0; headroom_ok = 1; in_ov = 0; tshut = 0;
    treg = 0; iset_open = 0; out_full = 0;
    wait_cyc(10);
    chk(mode, 4, "R5 active entry");
    chk(iref_sel, 1, "R6 full current");

    // R6 thermal regulation and open pin
    treg = 1; wait_cyc(8);
    chk(iref_sel, 3, "R6 reduced current");
    chk(mode, 4, "R6 treg keeps mode");
    iset_open = 1; wait_cyc(8);
    chk(iref_sel, 2, "R6 open overrides treg");
    treg = 0; iset_open = 0; wait_cyc(8);

    // R8 thermal shutdown, no blink
    tshut = 1; wait_cyc(10);
    chk(mode, 5, "R8 tshut standby");
    chk(chg_en, 0, "R8 tshut chg off");
    count_toggles(150, t);
    chk(t, 0, "R8 stat steady in tshut");
    tshut = 0; wait_cyc(10);
    chk(mode, 4, "R8 resume after tshut");

    // R7 overvoltage with blink
    in_ov = 1; wait_cyc(10);
    chk(mode, 5, "R7 ov standby");
    count_toggles(300, t);
    chk(t >= 5 && t <= 7, 1, "R11 blink in ov");
    in_ov = 0; wait_cyc(10);
    chk(mode, 4, "R7 auto resume");

    // R9 short overcurrent pulse
    ocp = 1; wait_cyc(DGL - 5); ocp = 0; wait_cyc(10);
    chk(mode, 4, "R9 short pulse ignored");
    chk(chg_en, 1, "R9 short pulse chg_en");
    ocp = 1; wait_cyc(DGL + 10); ocp = 0; wait_cyc(10);
    chk(mode, 6, "R9 long pulse latches");
    chk(chg_en, 0, "R9 latch chg off");
    count_toggles(300, t);
    chk(t >= 5 && t <= 7, 1, "R11 blink in fault");
    chk(mode, 6, "R10 fault persists");

    // R10 clear by enable toggle
    ce_n = 1; wait_cyc(10);
    chk(mode, 1, "R4 disabled");
    chk(chg_en, 0, "R4 disabled chg_en");
    ce_n = 0; wait_cyc(10);
    chk(mode, 4, "R10 cleared by ce toggle");

    // R5 short at startup check
    iset_short = 1;
    ce_n = 1; wait_cyc(10); ce_n = 0; wait_cyc(10);
    chk(mode, 6, "R5 short gives fault");
    chk(chg_en, 0, "R5 short chg_en");
    iset_short = 0; wait_cyc(20);
    chk(mode, 6, "R10 fault after short removed");
    in_ok = 0; wait_cyc(10);
    chk(mode, 0, "R1 input loss");
    chk(pg_n, 1, "R1 pg released");
    in_ok = 1; wait_cyc(10);
    chk(mode, 4, "R10 cleared by input cycle");

    // R12 no termination
    out_full = 1; wait_cyc(2000);
    chk(mode, 4, "R12 stays active");
    chk(chg_en, 1, "R12 chg_en held");
    chk(stat_n, 0, "R11 charged status low");
    chk(pg_n, 0, "R3 pg low when good");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule